// File: doc/BRIEF.md
# Refresh-Gated Processor Clock Generator

This block takes one master clock, nominally 14.31818 MHz, and derives from it every timing signal a small video terminal and its processor need. It emits a pixel clock-enable on every second master cycle and a processor phase-0 clock with a period of fourteen master cycles. A horizontal chain counts 65 processor periods per line. Four of those periods form a refresh window. Throughout the window the processor clock is held low so that dynamic memory can be refreshed, which brings the average processor rate down to about 0.960 MHz.

All outputs are registered in the master clock domain. The processor clock is a level, `phi0`, with single-cycle rise and fall strobes for downstream logic, so nothing downstream has to be clocked by a gated clock. A DMA request input takes the processor clock away from the block. The parameter `DMA_RELEASE` sets how. With the default value 0, the level is forced low. With 1, an output-enable (`phi0Oe`) is dropped so that pad logic can let another master drive the clock.

Top module: `cpu_clock_gen`

## Requirements
- R1: While `rst` is high on a clock edge, `phi0`, `phi0Rise`, `phi0Fall`, `pixEn` and `refreshActive` are low after that edge and `phi0Oe` is high. Edge number 0 is the first edge that samples `rst` low. It opens period 0 of line 0.
- R2: `pixEn` is high after every even-numbered edge since reset and low after every odd-numbered one. It is therefore high on every second master cycle.
- R3: After edge t, the position in the processor period is t mod 14. `phi0` is low for positions 0 to 6 and high for positions 7 to 13, so each high phase and each normal low phase lasts 7 master cycles.
- R4: The period index after edge t is (t div 14) mod 65. Periods 61 to 64 form the refresh window. `refreshActive` is high exactly during those periods, and `phi0` stays low throughout them. Without DMA, each line therefore has exactly 61 rising edges of `phi0`, and the low time that spans the window is 63 cycles.
- R5: `phi0Rise` is high for exactly the cycle in which `phi0` has just gone from 0 to 1. `phi0Fall` is high for exactly the cycle in which it has just gone from 1 to 0. At all other times both are low.
- R6: With `DMA_RELEASE` = 0, a high `dmaReq` sampled at an edge makes `phi0` low after that edge. The strobes follow the forced level, and `phi0Oe` stays high.
- R7: With `DMA_RELEASE` = 1, `phi0Oe` after an edge is the inverse of `dmaReq` sampled at that edge. `phi0` and its strobes are unaffected by `dmaReq`.
- R8: `dmaReq` never moves the period or line counters. Once it drops, `phi0` and `refreshActive` follow the same t-based schedule as a run without DMA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| dmaReq | input | 1 | DMA request, synchronous to `clk` |
| pixEn | output | 1 | Pixel clock-enable, every second cycle |
| phi0 | output | 1 | Registered processor phase-0 level |
| phi0Rise | output | 1 | One-cycle strobe when `phi0` goes high |
| phi0Fall | output | 1 | One-cycle strobe when `phi0` goes low |
| phi0Oe | output | 1 | Output-enable for the processor clock pad |
| refreshActive | output | 1 | High during the refresh periods of each line |

## Verification
The bench builds the block twice from the same stimulus:
- `u0` uses `DMA_RELEASE` = 0. It puts the force-low path of R6 within reach and shows the counters ride through DMA bursts (R8).
- `u1` uses `DMA_RELEASE` = 1. It puts the output-enable path of R7 within reach and shows that the same bursts leave its `phi0` untouched.

Both instances keep the default 14-cycle period, 65-period line and 4-period window. With these values, whole lines complete in a few thousand cycles. This lets the bench count edges per line and measure the 7- and 63-cycle phases.

// File: rtl/cpu_clock_gen_pkg.sv
package cpu_clock_gen_pkg;

  // Look-ahead decodes from the counter control to the output datapath,
  // describing the state that the next clock edge will enter.
  typedef struct packed {
    logic phaseHigh;   // next period position is in the high half
    logic refreshWin;  // next period index lies in the refresh window
  } phaseStrobes_t;

endpackage

// File: rtl/cpu_clock_ctrl.sv
module cpu_clock_ctrl
  import cpu_clock_gen_pkg::*;
#(
  parameter int DIV       = 14,
  parameter int LINE      = 65,
  parameter int REF_LEN   = 4,
  parameter int REF_START = LINE - REF_LEN
) (
  input  logic          clk,
  input  logic          rst,
  output phaseStrobes_t strobes
);

  localparam int DW       = $clog2(DIV);
  localparam int HW       = $clog2(LINE);
  localparam int HALF     = DIV / 2;
  localparam int REF_LAST = REF_START + REF_LEN - 1;

  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam logic [DW-1:0] HIGH_AT  = DW'(HALF);
  localparam logic [HW-1:0] LINE_LAST = HW'(LINE - 1);
  localparam logic [HW-1:0] WIN_LO   = HW'(REF_START);
  localparam logic [HW-1:0] WIN_HI   = HW'(REF_LAST);

  logic [DW-1:0] divCnt, divNxt;
  logic [HW-1:0] hCnt, hNxt;
  logic          periodEnd;

  always_comb begin
    periodEnd = (divCnt == DIV_LAST);
    divNxt    = periodEnd ? '0 : divCnt + 1'b1;
    if (periodEnd) begin
      hNxt = (hCnt == LINE_LAST) ? '0 : hCnt + 1'b1;
    end else begin
      hNxt = hCnt;
    end
    strobes.phaseHigh  = (divNxt >= HIGH_AT);
    strobes.refreshWin = (hNxt >= WIN_LO) && (hNxt <= WIN_HI);
  end

  // Reset parks both counters on their last value so that the first edge
  // after release wraps them to period 0, position 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= DIV_LAST;
      hCnt   <= LINE_LAST;
    end else begin
      divCnt <= divNxt;
      hCnt   <= hNxt;
    end
  end

  // R3
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    divCnt <= DIV_LAST);

  // R4
  line_range_chk: assert property (@(posedge clk) disable iff (rst)
    hCnt <= LINE_LAST);

  // R3
  div_step_chk: assert property (@(posedge clk) disable iff (rst)
    (divCnt != DIV_LAST) |=> (divCnt != '0));

endmodule

// File: rtl/cpu_clock_dp.sv
module cpu_clock_dp
  import cpu_clock_gen_pkg::*;
#(
  parameter bit DMA_RELEASE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dmaReq,
  input  phaseStrobes_t strobes,
  output logic          pixEn,
  output logic          phi0,
  output logic          phi0Rise,
  output logic          phi0Fall,
  output logic          phi0Oe,
  output logic          refreshActive
);

  logic dmaBlock;
  logic gateOpen;
  logic phiNxt;
  logic oeNxt;

  // The DMA variant picks both the force-low path and the output-enable.
  generate
    if (DMA_RELEASE) begin : g_release
      always_comb begin
        dmaBlock = 1'b0;
        oeNxt    = ~dmaReq;
      end
    end else begin : g_force_low
      always_comb begin
        dmaBlock = dmaReq;
        oeNxt    = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    gateOpen = ~strobes.refreshWin & ~dmaBlock;
    phiNxt   = strobes.phaseHigh & gateOpen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phi0          <= 1'b0;
      phi0Rise      <= 1'b0;
      phi0Fall      <= 1'b0;
      pixEn         <= 1'b0;
      refreshActive <= 1'b0;
      phi0Oe        <= 1'b1;
    end else begin
      phi0          <= phiNxt;
      phi0Rise      <= phiNxt & ~phi0;
      phi0Fall      <= ~phiNxt & phi0;
      pixEn         <= ~pixEn;
      refreshActive <= strobes.refreshWin;
      phi0Oe        <= oeNxt;
    end
  end

  // R2
  pix_alt_chk: assert property (@(posedge clk) disable iff (rst)
    pixEn |=> !pixEn);

  // R4
  no_rise_in_refresh_chk: assert property (@(posedge clk) disable iff (rst)
    refreshActive |-> !phi0);

  // R5
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    phi0Rise |=> !phi0Rise);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(phi0Rise && phi0Fall));

  generate
    if (DMA_RELEASE) begin : g_chk_release
      // R7
      dma_release_chk: assert property (@(posedge clk) disable iff (rst)
        dmaReq |=> !phi0Oe);
    end else begin : g_chk_force
      // R6
      dma_force_chk: assert property (@(posedge clk) disable iff (rst)
        dmaReq |=> (!phi0 && phi0Oe));
    end
  endgenerate

endmodule

// File: rtl/cpu_clock_gen.sv
module cpu_clock_gen
  import cpu_clock_gen_pkg::*;
#(
  parameter int DIV         = 14,
  parameter int LINE        = 65,
  parameter int REF_LEN     = 4,
  parameter int REF_START   = LINE - REF_LEN,
  parameter bit DMA_RELEASE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic dmaReq,
  output logic pixEn,
  output logic phi0,
  output logic phi0Rise,
  output logic phi0Fall,
  output logic phi0Oe,
  output logic refreshActive
);

  phaseStrobes_t strobes;

  cpu_clock_ctrl #(
    .DIV      (DIV),
    .LINE     (LINE),
    .REF_LEN  (REF_LEN),
    .REF_START(REF_START)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes)
  );

  cpu_clock_dp #(
    .DMA_RELEASE(DMA_RELEASE)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .dmaReq       (dmaReq),
    .strobes      (strobes),
    .pixEn        (pixEn),
    .phi0         (phi0),
    .phi0Rise     (phi0Rise),
    .phi0Fall     (phi0Fall),
    .phi0Oe       (phi0Oe),
    .refreshActive(refreshActive)
  );

endmodule

// File: tb/sim_cpu_clock_gen.sv
`timescale 1ns/1ps
module sim_cpu_clock_gen;

  logic clk = 1'b0;
  logic rst;
  logic dmaReq;

  logic pix0, phi0_0, rise0, fall0, oe0, ref0;
  logic pix1, phi0_1, rise1, fall1, oe1, ref1;

  always #10 clk = ~clk;

  cpu_clock_gen #(.DMA_RELEASE(1'b0)) u0 (
    .clk(clk), .rst(rst), .dmaReq(dmaReq),
    .pixEn(pix0), .phi0(phi0_0), .phi0Rise(rise0), .phi0Fall(fall0),
    .phi0Oe(oe0), .refreshActive(ref0));

  cpu_clock_gen #(.DMA_RELEASE(1'b1)) u1 (
    .clk(clk), .rst(rst), .dmaReq(dmaReq),
    .pixEn(pix1), .phi0(phi0_1), .phi0Rise(rise1), .phi0Fall(fall1),
    .phi0Oe(oe1), .refreshActive(ref1));

  int total = 0;
  int bad   = 0;
  int t;
  logic prevA, prevB;
  int rises, highRun, lowRun;
  bit finished = 0;

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s t=%0d actual=%b expected=%b", req, what, t, act, exp);
    end
  endtask

  task automatic chkInt(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s t=%0d actual=%0d expected=%0d", req, what, t, act, exp);
    end
  endtask

  task automatic checkReset();
    chk("R1", "u0 phi0", phi0_0, 1'b0);
    chk("R1", "u0 rise", rise0, 1'b0);
    chk("R1", "u0 fall", fall0, 1'b0);
    chk("R1", "u0 pixEn", pix0, 1'b0);
    chk("R1", "u0 refresh", ref0, 1'b0);
    chk("R1", "u0 oe", oe0, 1'b1);
    chk("R1", "u1 phi0", phi0_1, 1'b0);
    chk("R1", "u1 oe", oe1, 1'b1);
  endtask

  function automatic logic pickDma(int mode, int tt);
    if (mode == 0) return 1'b0;
    if (tt % 910 >= 300 && tt % 910 < 420) return 1'b1;
    return ((tt / 23) % 3) == 0;
  endfunction

  // One master cycle: set dmaReq, let an edge pass, compare at the falling edge.
  task automatic runSpan(int n, int mode);
    for (int i = 0; i < n; i++) begin
      logic d, pos, period, ungated, expA, expB, refr;
      d = pickDma(mode, t);
      dmaReq = d;
      @(posedge clk);
      @(negedge clk);
      pos     = ((t % 14) >= 7);
      period  = 1'b0;
      refr    = (((t / 14) % 65) >= 61);
      ungated = pos && !refr;
      expA    = ungated && !d;
      expB    = ungated;
      period  = period; // unused helper kept low
      // R2
      chk("R2", "u0 pixEn", pix0, (t % 2) == 0);
      chk("R2", "u1 pixEn", pix1, (t % 2) == 0);
      // R3 R4 R6 R8
      chk("R3", "u0 phi0", phi0_0, expA);
      chk("R4", "u0 refreshActive", ref0, refr);
      chk("R8", "u1 refreshActive", ref1, refr);
      // R5
      chk("R5", "u0 rise", rise0, expA && !prevA);
      chk("R5", "u0 fall", fall0, !expA && prevA);
      chk("R6", "u0 oe", oe0, 1'b1);
      // R7
      chk("R7", "u1 phi0", phi0_1, expB);
      chk("R7", "u1 rise", rise1, expB && !prevB);
      chk("R7", "u1 fall", fall1, !expB && prevB);
      chk("R7", "u1 oe", oe1, !d);
      prevA = expA;
      prevB = expB;
      if (mode == 0) begin
        if (rise0) begin
          rises++;
          total++;
          if (lowRun != 7 && lowRun != 63) begin
            bad++;
            $display("FAIL R4 low run t=%0d actual=%0d expected=7 or 63", t, lowRun);
          end
          lowRun  = 0;
          highRun = 1;
        end else if (fall0) begin
          chkInt("R3", "high run", highRun, 7);
          highRun = 0;
          lowRun  = 1;
        end else if (phi0_0) begin
          highRun++;
        end else begin
          lowRun++;
        end
        if (refr && (rise0 || phi0_0))
          chk("R4", "edge in refresh", 1'b1, 1'b0);
        if (t % 910 == 909) begin
          chkInt("R4", "rises per line", rises, 61);
          rises = 0;
        end
      end
      t++;
    end
  endtask

  task automatic restart();
    t = 0; prevA = 0; prevB = 0;
    rises = 0; highRun = 0; lowRun = 0;
  endtask

  initial begin
    rst = 1'b1;
    dmaReq = 1'b0;
    repeat (4) @(negedge clk);
    checkReset();
    rst = 1'b0;
    restart();
    runSpan(3 * 910, 0);
    runSpan(3 * 910, 1);
    // after DMA bursts the schedule is unchanged (R8), edge counts intact
    runSpan(910, 0);
    rst = 1'b1;
    dmaReq = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset dominates an active DMA request
    checkReset();
    rst = 1'b0;
    restart();
    runSpan(910, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule